// File: doc/BRIEF.md
# Indexed Register Window for a Disc Data Decoder

This block gives a host processor access to the sixteen byte-wide control and status registers of a disc sector decoder through only two locations: an index location and a data location. The host writes a 4-bit slot number into the index location, then reads or writes the data location as many times as it needs. After most data accesses the index moves on by one, so a whole group of registers can be walked with back-to-back accesses and no re-addressing.

Some data accesses do more than move a byte. Reads of the decode-result registers are recorded in a visit map. Reading the final status byte clears the pending decode interrupt and, when the host has enabled it and has visited every decode-result register, marks that status byte as ready. Writes to the command slots start or stop a transfer, acknowledge the end-of-transfer interrupt, or return every register to its power-up value. The transfer datapath sits outside: it takes one-cycle start and stop pulses plus the address, length and control bytes, and it reports completion back through `xfer_done`. A separate `decode_evt` pulse from the decoder raises the decode interrupt.

Top module: `cdw_regport`

## Requirements
- R1: After reset the index reads 0, and data reads of slots 0 to 15 return 00, FF, 00, 00, 00, 00, 00, 01, 00, 00, 60, 12, 80, 00, 00, 00 (header and status words are little-endian by slot; the write address is 4704).
- R2: A data read at slots 0 to 14 returns that slot's byte and moves the index to the next slot; the slots in order are command-in, interrupt status, count low, count high, header 0 to 3, pointer low, pointer high, write address low, write address high, status 0 to 2.
- R3: A data read at slot 15 returns status byte 3 and leaves the index at 15.
- R4: Data writes at slots 0 to 5 and 8 to 13 store subcode-out, interface control, count low/high, transfer address low/high, write address low/high, control 0, control 1, pointer low/high, and advance the index; writes at slots 6, 7, 14 and 15 leave the index where it is (slot 14 stores control 2).
- R5: A write to the index location (addr = 0) loads the index from wdata[3:0]; a read of it returns the index in the low four bits.
- R6: A read of slot 15 sets interrupt status bit 5; status byte 3 then becomes 80 only if control 0 bit 7 and interface control bit 5 are set and slots 1, 4 to 9 and 12 to 14 have all been read since the last reset; `decode_evt` clears interrupt status bit 5.
- R7: Writing interface control with bit 1 clear zeroes the byte count, sets interrupt status bit 3, clears `xfer_busy` and pulses `xfer_stop`.
- R8: A write at slot 6 with interface control bit 1 set pulses `xfer_start`, sets `xfer_busy` and clears interrupt status bit 3; with bit 1 clear it has no effect.
- R9: `xfer_done` while busy clears `xfer_busy`, sets interrupt status bit 3 and, if interface control bit 6 is set, clears interrupt status bit 6; a write at slot 7 sets bit 6 again.
- R10: A write at slot 15 returns every register and the visit map to the R1 values, pulses `xfer_stop`, and keeps the index.
- R11: Read data appears on `rdata` with `rd_valid` high one clock after the access and holds until the next read.
- R12: With `cs` low nothing changes, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Access strobe, one access per cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 1 | 0 = index location, 1 = data location |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rd_valid | output | 1 | High the cycle after a read |
| decode_evt | input | 1 | Decoder event, raises the decode interrupt |
| xfer_done | input | 1 | Transfer datapath reports completion |
| xfer_start | output | 1 | One-cycle transfer start pulse |
| xfer_stop | output | 1 | One-cycle transfer stop pulse |
| xfer_busy | output | 1 | Transfer in progress |
| xfer_addr | output | 16 | Transfer address register |
| xfer_len | output | 16 | Byte count register |
| cdc_ctrl | output | 24 | Control bytes 2, 1, 0 |
| sb_byte | output | 8 | Subcode-out byte |

## Verification
The window is walked from slot 0 to slot 15 after reset, after a series of writes and after a soft reset, which separates the per-slot stepping rule from a plain increment and shows the stored values land in the right slots. The ready marking of the last status byte is tried once with only part of the decode-result slots visited and once with all of them, so a missing or extra bit in the visit map shows as a wrong status byte. Start, stop and acknowledge writes are tried with the enable bit both set and clear, and with completion and decode events in between, which tells the interrupt status bits apart from one another.

// File: rtl/cdw_pkg.sv
package cdw_pkg;
  localparam int INDEX_W = 4;
  localparam int NSLOT   = 1 << INDEX_W;

  localparam logic [INDEX_W-1:0] SLOT_IFCTL = 4'd1;
  localparam logic [INDEX_W-1:0] SLOT_START = 4'd6;
  localparam logic [INDEX_W-1:0] SLOT_ACK   = 4'd7;
  localparam logic [INDEX_W-1:0] SLOT_CTL2  = 4'd14;
  localparam logic [INDEX_W-1:0] SLOT_LAST  = 4'd15;

  // slots whose reads are recorded in the visit map
  localparam logic [NSLOT-1:0] TRACK_MASK = 16'h73F2;

  function automatic logic steps_on_read(input logic [INDEX_W-1:0] i);
    return i != SLOT_LAST;
  endfunction

  function automatic logic steps_on_write(input logic [INDEX_W-1:0] i);
    return !(i == SLOT_START || i == SLOT_ACK || i == SLOT_CTL2 || i == SLOT_LAST);
  endfunction
endpackage

// File: rtl/cdw_index.sv
module cdw_index
  import cdw_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [INDEX_W-1:0] load_val,
  input  logic               step,
  output logic [INDEX_W-1:0] idx
);
  always_ff @(posedge clk) begin
    if (rst)       idx <= '0;
    else if (load) idx <= load_val;
    else if (step) idx <= idx + 1'b1;
  end
endmodule

// File: rtl/cdw_regs.sv
module cdw_regs
  import cdw_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0]   IFSTAT_RST = 8'hFF,
  parameter logic [4*DW-1:0] HDR_RST    = 32'h0100_0000,
  parameter logic [2*DW-1:0] WADR_RST   = 16'd4704,
  parameter logic [4*DW-1:0] STAT_RST   = 32'h0000_0080
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_en,
  input  logic                     wr_en,
  input  logic [INDEX_W-1:0]       idx,
  input  logic [DW-1:0]            wdata,
  input  logic                     decode_evt,
  input  logic                     xfer_done,
  output logic [NSLOT-1:0][DW-1:0] view,
  output logic                     start_q,
  output logic                     stop_q,
  output logic                     busy,
  output logic [2*DW-1:0]          dma_adr,
  output logic [2*DW-1:0]          byte_cnt,
  output logic [3*DW-1:0]          ctl,
  output logic [DW-1:0]            sb_out
);
  localparam logic [DW-1:0] READY_VAL = 8'h80;

  logic [DW-1:0]    cmd_in, if_stat, if_ctl;
  logic [4*DW-1:0]  hdr, stat;
  logic [2*DW-1:0]  ptr, wr_adr;
  logic [NSLOT-1:0] visited;
  logic             soft_clr;
  logic             all_seen;

  assign soft_clr = wr_en && idx == SLOT_LAST;
  assign all_seen = (visited & TRACK_MASK) == TRACK_MASK;

  always_ff @(posedge clk) begin
    if (rst || soft_clr) begin
      cmd_in   <= '0;
      if_stat  <= IFSTAT_RST;
      if_ctl   <= '0;
      hdr      <= HDR_RST;
      stat     <= STAT_RST;
      ptr      <= '0;
      wr_adr   <= WADR_RST;
      dma_adr  <= '0;
      byte_cnt <= '0;
      ctl      <= '0;
      sb_out   <= '0;
      visited  <= '0;
      busy     <= 1'b0;
    end else begin
      // events from the decoder and datapath first, host access may override
      if (decode_evt) if_stat[5] <= 1'b0;
      if (xfer_done && busy) begin
        busy       <= 1'b0;
        if_stat[3] <= 1'b1;
        if (if_ctl[6]) if_stat[6] <= 1'b0;
      end
      if (rd_en) begin
        visited <= visited | (TRACK_MASK & (NSLOT'(1) << idx));
        if (idx == SLOT_LAST) begin
          if_stat[5] <= 1'b1;
          if (ctl[7] && if_ctl[5] && all_seen) stat[4*DW-1 -: DW] <= READY_VAL;
        end
      end
      if (wr_en) begin
        unique case (idx)
          4'd0:  sb_out <= wdata;
          4'd1: begin
            if_ctl <= wdata;
            if (!wdata[1]) begin
              byte_cnt   <= '0;
              if_stat[3] <= 1'b1;
              busy       <= 1'b0;
            end
          end
          4'd2:  byte_cnt[DW-1:0]    <= wdata;
          4'd3:  byte_cnt[2*DW-1:DW] <= wdata;
          4'd4:  dma_adr[DW-1:0]     <= wdata;
          4'd5:  dma_adr[2*DW-1:DW]  <= wdata;
          4'd6: begin
            if (if_ctl[1]) begin
              if_stat[3] <= 1'b0;
              busy       <= 1'b1;
            end
          end
          4'd7:  if_stat[6] <= 1'b1;
          4'd8:  wr_adr[DW-1:0]      <= wdata;
          4'd9:  wr_adr[2*DW-1:DW]   <= wdata;
          4'd10: ctl[DW-1:0]         <= wdata;
          4'd11: ctl[2*DW-1:DW]      <= wdata;
          4'd12: ptr[DW-1:0]         <= wdata;
          4'd13: ptr[2*DW-1:DW]      <= wdata;
          4'd14: ctl[3*DW-1:2*DW]    <= wdata;
          default: ;
        endcase
      end
    end
  end

  // one-cycle strobes towards the transfer datapath
  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      start_q <= wr_en && idx == SLOT_START && if_ctl[1];
      stop_q  <= soft_clr || (wr_en && idx == SLOT_IFCTL && !wdata[1]);
    end
  end

  always_comb begin
    view[0]  = cmd_in;
    view[1]  = if_stat;
    view[2]  = byte_cnt[DW-1:0];
    view[3]  = byte_cnt[2*DW-1:DW];
    for (int k = 0; k < 4; k++) begin
      view[4+k]  = hdr[k*DW +: DW];
      view[12+k] = stat[k*DW +: DW];
    end
    view[8]  = ptr[DW-1:0];
    view[9]  = ptr[2*DW-1:DW];
    view[10] = wr_adr[DW-1:0];
    view[11] = wr_adr[2*DW-1:DW];
  end

  p_last_read_clears_irq_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && idx == SLOT_LAST) |=> if_stat[5]);

  p_ready_needs_enable_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && idx == SLOT_LAST && !ctl[7] && !wr_en) |=> $stable(stat[4*DW-1 -: DW]));

  p_stop_clears_count_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx == SLOT_IFCTL && !wdata[1]) |=> (byte_cnt == '0 && if_stat[3] && stop_q && !busy));

  p_start_sets_busy_r8: assert property (@(posedge clk) disable iff (rst)
    start_q |-> (busy && !if_stat[3]));

  p_ack_sets_flag_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx == SLOT_ACK) |=> if_stat[6]);

  p_strobes_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
    !(start_q && stop_q));
endmodule

// File: rtl/cdw_rdmux.sv
module cdw_rdmux
  import cdw_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_any,
  input  logic                     rd_index,
  input  logic [INDEX_W-1:0]       idx,
  input  logic [NSLOT-1:0][DW-1:0] view,
  output logic [DW-1:0]            rdata,
  output logic                     rd_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_any;
      if (rd_any) rdata <= rd_index ? DW'(idx) : view[idx];
    end
  end

  p_read_latency_r11: assert property (@(posedge clk) disable iff (rst)
    rd_any |=> rd_valid);

  p_rdata_holds_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_any |=> $stable(rdata));
endmodule

// File: rtl/cdw_regport.sv
module cdw_regport
  import cdw_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs,
  input  logic          we,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rd_valid,
  input  logic          decode_evt,
  input  logic          xfer_done,
  output logic          xfer_start,
  output logic          xfer_stop,
  output logic          xfer_busy,
  output logic [2*DW-1:0] xfer_addr,
  output logic [2*DW-1:0] xfer_len,
  output logic [3*DW-1:0] cdc_ctrl,
  output logic [DW-1:0] sb_byte
);
  logic                     data_rd, data_wr, idx_wr, idx_rd, step;
  logic [INDEX_W-1:0]       idx;
  logic [NSLOT-1:0][DW-1:0] view;

  assign data_rd = cs && !we && addr;
  assign data_wr = cs && we && addr;
  assign idx_wr  = cs && we && !addr;
  assign idx_rd  = cs && !we && !addr;
  assign step    = (data_rd && steps_on_read(idx)) || (data_wr && steps_on_write(idx));

  cdw_index u_index (
    .clk(clk), .rst(rst), .load(idx_wr), .load_val(wdata[INDEX_W-1:0]),
    .step(step), .idx(idx)
  );

  cdw_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .rd_en(data_rd), .wr_en(data_wr), .idx(idx),
    .wdata(wdata), .decode_evt(decode_evt), .xfer_done(xfer_done),
    .view(view), .start_q(xfer_start), .stop_q(xfer_stop), .busy(xfer_busy),
    .dma_adr(xfer_addr), .byte_cnt(xfer_len), .ctl(cdc_ctrl), .sb_out(sb_byte)
  );

  cdw_rdmux #(.DW(DW)) u_rdmux (
    .clk(clk), .rst(rst), .rd_any(data_rd || idx_rd), .rd_index(idx_rd),
    .idx(idx), .view(view), .rdata(rdata), .rd_valid(rd_valid)
  );

  p_last_slot_holds_r3: assert property (@(posedge clk) disable iff (rst)
    (data_rd && idx == SLOT_LAST) |=> idx == SLOT_LAST);

  p_cmd_slots_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (data_wr && (idx == SLOT_START || idx == SLOT_ACK)) |=> $stable(idx));

  p_index_load_r5: assert property (@(posedge clk) disable iff (rst)
    idx_wr |=> idx == $past(wdata[INDEX_W-1:0]));

  p_idle_stable_r12: assert property (@(posedge clk) disable iff (rst)
    !cs |=> ($stable(idx) && $stable(xfer_len) && $stable(cdc_ctrl)));
endmodule

// File: tb/sim_cdw_regport.sv
module sim_cdw_regport;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs = 1'b0, we = 1'b0, addr = 1'b0;
  logic [7:0]  wdata = '0;
  logic        decode_evt = 1'b0, xfer_done = 1'b0;
  logic [7:0]  rdata;
  logic        rd_valid, xfer_start, xfer_stop, xfer_busy;
  logic [15:0] xfer_addr, xfer_len;
  logic [23:0] cdc_ctrl;
  logic [7:0]  sb_byte;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         done = 1'b0;

  always #4 clk = ~clk;

  cdw_regport u0 (
    .clk(clk), .rst(rst), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rd_valid(rd_valid), .decode_evt(decode_evt),
    .xfer_done(xfer_done), .xfer_start(xfer_start), .xfer_stop(xfer_stop),
    .xfer_busy(xfer_busy), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
    .cdc_ctrl(cdc_ctrl), .sb_byte(sb_byte)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected byte per valid read
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R11 unexpected rd_valid", 1, 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(rdata === e, t, rdata, e);
      end
    end
  end

  task automatic access(input logic w, input logic a, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic set_idx(input logic [7:0] v);
    access(1'b1, 1'b0, v);
  endtask

  task automatic wr_data(input logic [7:0] v);
    access(1'b1, 1'b1, v);
  endtask

  task automatic rd_data(input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    access(1'b0, 1'b1, 8'h00);
  endtask

  task automatic rd_idx(input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    access(1'b0, 1'b0, 8'h00);
  endtask

  task automatic pulse_done();
    @(negedge clk); xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
  endtask

  task automatic pulse_decode();
    @(negedge clk); decode_evt = 1'b1;
    @(negedge clk); decode_evt = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] rst_vals [16];
    rst_vals = '{8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01,
                 8'h00, 8'h00, 8'h60, 8'h12, 8'h80, 8'h00, 8'h00, 8'h00};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(rd_valid === 1'b0 && xfer_busy === 1'b0, "R1 reset outputs", xfer_busy, 0);

    // R1/R2: walk after reset
    rd_idx(8'h00, "R1 index after reset");
    set_idx(8'h00);
    for (int i = 0; i < 16; i++) rd_data(rst_vals[i], $sformatf("R1 R2 reset slot %0d", i));
    rd_data(8'h00, "R3 repeat read of slot 15");
    rd_idx(8'h0F, "R3 index stays at 15");

    // R4/R5: writes 0..5
    set_idx(8'h00);
    wr_data(8'hAA); wr_data(8'h62); wr_data(8'h34); wr_data(8'h12);
    wr_data(8'h00); wr_data(8'h10);
    rd_idx(8'h06, "R4 R5 index after six writes");
    check(xfer_addr === 16'h1000, "R4 transfer address", xfer_addr, 16'h1000);
    check(xfer_len === 16'h1234, "R4 byte count", xfer_len, 16'h1234);
    check(sb_byte === 8'hAA, "R4 subcode byte", sb_byte, 8'hAA);

    // R8: start with enable set
    wr_data(8'h99);
    check(xfer_start === 1'b1, "R8 start pulse", xfer_start, 1);
    check(xfer_busy === 1'b1, "R8 busy after start", xfer_busy, 1);
    rd_idx(8'h06, "R4 slot 6 holds index");
    set_idx(8'h01);
    rd_data(8'hF7, "R8 status bit3 cleared");
    rd_data(8'h34, "R4 count low");
    rd_data(8'h12, "R4 count high");

    // R9: completion then acknowledge
    pulse_done();
    check(xfer_busy === 1'b0, "R9 busy cleared by done", xfer_busy, 0);
    set_idx(8'h01);
    rd_data(8'hBF, "R9 status after done");
    set_idx(8'h07);
    wr_data(8'h00);
    rd_idx(8'h07, "R4 slot 7 holds index");
    set_idx(8'h01);
    rd_data(8'hFF, "R9 status after acknowledge");

    // R4: writes 8..14
    set_idx(8'h08);
    wr_data(8'h11); wr_data(8'h22); wr_data(8'h80); wr_data(8'h01);
    wr_data(8'h44); wr_data(8'h55);
    rd_idx(8'h0E, "R4 index after writes 8..13");
    wr_data(8'h07);
    rd_idx(8'h0E, "R4 slot 14 holds index");
    check(cdc_ctrl === 24'h070180, "R4 control bytes", cdc_ctrl, 24'h070180);
    set_idx(8'h08);
    rd_data(8'h44, "R4 pointer low");
    rd_data(8'h55, "R4 pointer high");
    rd_data(8'h11, "R4 write address low");
    rd_data(8'h22, "R4 write address high");

    // R10: soft reset
    set_idx(8'h0F);
    wr_data(8'h00);
    check(xfer_stop === 1'b1, "R10 stop pulse on soft reset", xfer_stop, 1);
    rd_idx(8'h0F, "R10 index kept");
    check(cdc_ctrl === 24'h0 && xfer_len === 16'h0, "R10 control cleared", cdc_ctrl, 0);
    set_idx(8'h0A);
    rd_data(8'h60, "R10 write address low restored");
    rd_data(8'h12, "R10 write address high restored");

    // R6: ready marking, partial then full visit
    set_idx(8'h0A);
    wr_data(8'h80);
    set_idx(8'h01);
    wr_data(8'h22);
    set_idx(8'h0C);
    rd_data(8'h80, "R6 status 0"); rd_data(8'h00, "R6 status 1");
    rd_data(8'h00, "R6 status 2"); rd_data(8'h00, "R6 status 3 first");
    rd_data(8'h00, "R6 not ready with partial visit");
    pulse_decode();
    set_idx(8'h01);
    rd_data(8'hDF, "R6 decode event clears bit5");
    set_idx(8'h04);
    rd_data(8'h00, "R6 hdr0"); rd_data(8'h00, "R6 hdr1");
    rd_data(8'h00, "R6 hdr2"); rd_data(8'h01, "R6 hdr3");
    rd_data(8'h00, "R6 ptr low"); rd_data(8'h00, "R6 ptr high");
    set_idx(8'h0C);
    rd_data(8'h80, "R6 status 0"); rd_data(8'h00, "R6 status 1");
    rd_data(8'h00, "R6 status 2"); rd_data(8'h00, "R6 status 3 before ready");
    rd_data(8'h80, "R6 ready after full visit");
    set_idx(8'h01);
    rd_data(8'hFF, "R6 bit5 set by last read");

    // R7: stop
    set_idx(8'h02);
    wr_data(8'h55); wr_data(8'h66);
    check(xfer_len === 16'h6655, "R4 count write", xfer_len, 16'h6655);
    set_idx(8'h06);
    wr_data(8'h00);
    check(xfer_busy === 1'b1, "R8 start again", xfer_busy, 1);
    set_idx(8'h01);
    wr_data(8'h20);
    check(xfer_stop === 1'b1, "R7 stop pulse", xfer_stop, 1);
    check(xfer_busy === 1'b0, "R7 busy cleared", xfer_busy, 0);
    check(xfer_len === 16'h0, "R7 count zeroed", xfer_len, 0);
    set_idx(8'h01);
    rd_data(8'hFF, "R7 status bit3 set");
    rd_data(8'h00, "R7 count low zero");
    rd_data(8'h00, "R7 count high zero");

    // R8: start ignored without enable
    set_idx(8'h06);
    wr_data(8'h00);
    check(xfer_start === 1'b0, "R8 no start without enable", xfer_start, 0);
    check(xfer_busy === 1'b0, "R8 stays idle", xfer_busy, 0);

    // R12: idle inputs with cs low
    @(negedge clk);
    we = 1'b1; addr = 1'b1; wdata = 8'h3C;
    repeat (3) @(negedge clk);
    we = 1'b0; addr = 1'b0;
    check(xfer_len === 16'h0 && rd_valid === 1'b0, "R12 no change while idle", xfer_len, 0);
    rd_idx(8'h06, "R12 index unchanged while idle");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R11 all reads returned", exp_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule